// File: doc/BRIEF.md
# Indirect Branch Target Range and Alignment Checker

This block decides whether the target pointer of an indirect branch may be used. With each request comes a descriptor: the address of the first allowed entry, the log2 of the entry spacing, the number of entries, a check kind and an inline membership vector of up to 64 bits. The unit subtracts the base from the pointer and rotates the difference right by the spacing. Misaligned low bits land in the upper bits of the rotated value, so one unsigned compare against the last valid index covers both the bounds test and the alignment test. The rotated value then picks a bit of the membership vector.

Four check kinds exist: a 64-bit vector, a 32-bit vector, an equality-only check for a single allowed address, and an all-ones check that skips the bit lookup. A failed check either raises a trap or asks for a redirect to a failure or slow-path address carried with the request. A per-request mode bit chooses which.

The control is a two-state machine. In `ST_IDLE` the unit accepts a request (`req_valid && req_ready`), registers the verdict and moves to `ST_RESULT`. In `ST_RESULT` it presents the verdict and goes back to `ST_IDLE` when `rsp_ready` is high. Otherwise it stays in `ST_RESULT`.

Top module: `cfi_target_checker`

## Requirements
- R1: After reset `req_ready` is 1. An accepted request makes `rsp_valid` 1 on the next cycle. `rsp_valid` and the verdict stay unchanged until `rsp_ready` is 1, and `req_ready` is 0 throughout.
- R2: While `rsp_valid` is 1, exactly one of `rsp_pass`, `rsp_trap` and `rsp_redirect` is 1.
- R3: The index is (target − base) mod 2^AW, rotated right by `req_shift`. The vector kinds and the all-ones kind require index ≤ count − 1, compared unsigned. A pointer below the base, beyond the last entry, or not on the spacing therefore fails.
- R4: In every kind except equality, a count of 0 fails every pointer.
- R5: Kind 2'b00 (64-bit vector) passes only when the range test holds and bit[index] of `req_bits` is 1.
- R6: Kind 2'b01 (32-bit vector) uses only `req_bits[31:0]`. An index of 32 or more fails even when the matching upper bit is 1.
- R7: Kind 2'b10 (equality) passes exactly when target equals base. Count, shift and vector are ignored.
- R8: Kind 2'b11 (all-ones) passes on the range test alone and ignores `req_bits`.
- R9: A failed check sets `rsp_trap` when `req_redirect` is 0. When `req_redirect` is 1 it sets `rsp_redirect` and puts `req_fail_target` on `rsp_fail_target`. In every other case `rsp_fail_target` is 0.
- R10: During and right after reset, `rsp_valid`, all three verdict flags and `rsp_fail_target` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request (`ST_IDLE`) |
| req_target | input | AW | Pointer under test |
| req_base | input | AW | Address of first allowed entry |
| req_shift | input | SHW | log2 of entry spacing in bytes |
| req_count | input | AW | Number of entries covered |
| req_kind | input | 2 | Check kind (00 vec64, 01 vec32, 10 equality, 11 all-ones) |
| req_bits | input | VW | Inline membership vector |
| req_redirect | input | 1 | Failure action: 0 trap, 1 redirect |
| req_fail_target | input | AW | Redirect address on failure |
| rsp_valid | output | 1 | Verdict present (`ST_RESULT`) |
| rsp_ready | input | 1 | Consumer takes the verdict |
| rsp_pass | output | 1 | Target allowed |
| rsp_trap | output | 1 | Failure, trap requested |
| rsp_redirect | output | 1 | Failure, redirect requested |
| rsp_fail_target | output | AW | Redirect address, 0 unless redirecting |

## Verification
The assertions assume that request fields are stable while `req_valid` is high. They also assume that `req_shift` stays below AW and that the descriptor has already been stripped, so the base is the first allowed entry. The bench changes request fields only on the falling edge before a cycle in which it raises `req_valid`. It keeps every shift between 0 and 5, and it builds every base and count so that they describe a stripped vector.

// File: rtl/cfi_chk_pkg.sv
package cfi_chk_pkg;
    typedef enum logic [1:0] {
        KIND_VEC64  = 2'b00,
        KIND_VEC32  = 2'b01,
        KIND_EQUAL  = 2'b10,
        KIND_ALLONE = 2'b11
    } chk_kind_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } chk_state_e;

    localparam int unsigned NARROW_BITS = 32;
endpackage

// File: rtl/cfi_offset_rotator.sv
module cfi_offset_rotator #(
    parameter int unsigned AW  = 64,
    parameter int unsigned SHW = $clog2(AW)
) (
    input  logic [AW-1:0]  target,
    input  logic [AW-1:0]  base,
    input  logic [SHW-1:0] shift,
    output logic [AW-1:0]  index
);
    logic [AW-1:0]   offset;
    logic [2*AW-1:0] doubled;

    always_comb begin
        offset  = target - base;
        // rotating right: low bits of the doubled word shifted down
        doubled = {offset, offset} >> shift;
        index   = doubled[AW-1:0];
    end
endmodule

// File: rtl/cfi_range_gate.sv
module cfi_range_gate #(
    parameter int unsigned AW = 64
) (
    input  logic [AW-1:0] index,
    input  logic [AW-1:0] count,
    output logic          in_range
);
    logic [AW-1:0] last_idx;

    always_comb begin
        last_idx = count - AW'(1);
        in_range = (count != '0) && (index <= last_idx);
    end
endmodule

// File: rtl/cfi_vector_probe.sv
module cfi_vector_probe #(
    parameter int unsigned AW     = 64,
    parameter int unsigned VW     = 64,
    parameter int unsigned NARROW = 32
) (
    input  logic [AW-1:0] index,
    input  logic [VW-1:0] bits,
    input  logic          wide,
    output logic          bit_set
);
    logic [VW-1:0] lane_hit;

    generate
        for (genvar g = 0; g < VW; g++) begin : g_lane
            if (g < NARROW) begin : g_low
                assign lane_hit[g] = (index == AW'(g)) && bits[g];
            end else begin : g_high
                assign lane_hit[g] = wide && (index == AW'(g)) && bits[g];
            end
        end
    endgenerate

    assign bit_set = |lane_hit;
endmodule

// File: rtl/cfi_target_checker.sv
module cfi_target_checker
    import cfi_chk_pkg::*;
#(
    parameter int unsigned AW  = 64,
    parameter int unsigned VW  = 64,
    parameter int unsigned SHW = $clog2(AW)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic [AW-1:0]  req_target,
    input  logic [AW-1:0]  req_base,
    input  logic [SHW-1:0] req_shift,
    input  logic [AW-1:0]  req_count,
    input  logic [1:0]     req_kind,
    input  logic [VW-1:0]  req_bits,
    input  logic           req_redirect,
    input  logic [AW-1:0]  req_fail_target,
    output logic           rsp_valid,
    input  logic           rsp_ready,
    output logic           rsp_pass,
    output logic           rsp_trap,
    output logic           rsp_redirect,
    output logic [AW-1:0]  rsp_fail_target
);
    chk_state_e    state_q, state_d;
    chk_kind_e     kind;
    logic [AW-1:0] index;
    logic          in_range;
    logic          bit_set;
    logic          wide;
    logic          allowed;
    logic          accept;

    logic          pass_q, trap_q, redir_q;
    logic [AW-1:0] ftgt_q;

    cfi_offset_rotator #(.AW(AW), .SHW(SHW)) i_rot (
        .target (req_target),
        .base   (req_base),
        .shift  (req_shift),
        .index  (index)
    );

    cfi_range_gate #(.AW(AW)) i_range (
        .index    (index),
        .count    (req_count),
        .in_range (in_range)
    );

    cfi_vector_probe #(.AW(AW), .VW(VW), .NARROW(NARROW_BITS)) i_probe (
        .index   (index),
        .bits    (req_bits),
        .wide    (wide),
        .bit_set (bit_set)
    );

    always_comb begin
        kind    = chk_kind_e'(req_kind);
        wide    = (kind == KIND_VEC64);
        allowed = 1'b0;
        unique case (kind)
            KIND_VEC64:  allowed = in_range && bit_set;
            KIND_VEC32:  allowed = in_range && bit_set;
            KIND_EQUAL:  allowed = (req_target == req_base);
            KIND_ALLONE: allowed = in_range;
        endcase
    end

    assign accept = req_valid && (state_q == ST_IDLE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_RESULT;
            ST_RESULT: if (rsp_ready) state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // verdict register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass_q  <= 1'b0;
            trap_q  <= 1'b0;
            redir_q <= 1'b0;
            ftgt_q  <= '0;
        end else if (accept) begin
            pass_q  <= allowed;
            trap_q  <= !allowed && !req_redirect;
            redir_q <= !allowed && req_redirect;
            ftgt_q  <= (!allowed && req_redirect) ? req_fail_target : '0;
        end
    end

    // outputs
    always_comb begin
        req_ready       = 1'b0;
        rsp_valid       = 1'b0;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_RESULT: rsp_valid = 1'b1;
        endcase
        rsp_pass        = pass_q;
        rsp_trap        = trap_q;
        rsp_redirect    = redir_q;
        rsp_fail_target = ftgt_q;
    end
endmodule

// File: rtl/cfi_target_checker_sva.sv
module cfi_target_checker_sva #(
    parameter int unsigned AW  = 64,
    parameter int unsigned VW  = 64,
    parameter int unsigned SHW = $clog2(AW)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_valid,
    input logic           req_ready,
    input logic [AW-1:0]  req_target,
    input logic [AW-1:0]  req_base,
    input logic [SHW-1:0] req_shift,
    input logic [AW-1:0]  req_count,
    input logic [1:0]     req_kind,
    input logic [VW-1:0]  req_bits,
    input logic           req_redirect,
    input logic [AW-1:0]  req_fail_target,
    input logic           rsp_valid,
    input logic           rsp_ready,
    input logic           rsp_pass,
    input logic           rsp_trap,
    input logic           rsp_redirect,
    input logic [AW-1:0]  rsp_fail_target
);
    p_accept_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    p_hold_verdict_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable({rsp_pass, rsp_trap, rsp_redirect, rsp_fail_target})));

    p_no_overlap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && rsp_valid));

    p_onehot_verdict_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot({rsp_pass, rsp_trap, rsp_redirect}));

    p_zero_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_kind != 2'b10 && req_count == '0) |=> !rsp_pass);

    p_equal_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_kind == 2'b10 && req_target == req_base) |=> rsp_pass);

    p_fail_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_redirect) |-> (rsp_fail_target == '0));

    p_trap_choice_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_redirect) |=> !rsp_trap);
endmodule

bind cfi_target_checker cfi_target_checker_sva #(.AW(AW), .VW(VW), .SHW(SHW)) i_sva (.*);

// File: tb/test_cfi_target_checker.sv
module test_cfi_target_checker;
    localparam int unsigned AW = 64;
    localparam int unsigned VW = 64;
    localparam int unsigned SHW = 6;
    localparam time CLK_PERIOD = 10ns;
    localparam int unsigned WATCHDOG = 5000;

    localparam logic [1:0] K64 = 2'b00, K32 = 2'b01, KEQ = 2'b10, KONE = 2'b11;
    localparam logic [1:0] E_PASS = 2'd0, E_TRAP = 2'd1, E_REDIR = 2'd2;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    typedef struct packed {
        logic [15:0]    tag;
        logic [AW-1:0]  tgt;
        logic [AW-1:0]  base;
        logic [SHW-1:0] sh;
        logic [AW-1:0]  cnt;
        logic [1:0]     kind;
        logic [VW-1:0]  bits;
        logic           redir;
        logic [AW-1:0]  ftgt;
        logic [1:0]     exp;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        '{"R5", 64'h1040, 64'h1000, 6'd5, 64'd4,  K64,  64'hB,         1'b0, 64'h0,     E_TRAP},
        '{"R5", 64'h1060, 64'h1000, 6'd5, 64'd4,  K64,  64'hB,         1'b0, 64'h0,     E_PASS},
        '{"R3", 64'h1048, 64'h1000, 6'd5, 64'd4,  K64,  64'hF,         1'b1, 64'hDEAD0, E_REDIR},
        '{"R3", 64'h0FE0, 64'h1000, 6'd5, 64'd4,  K64,  64'hF,         1'b0, 64'h0,     E_TRAP},
        '{"R3", 64'h1080, 64'h1000, 6'd5, 64'd4,  K64,  ONES,          1'b0, 64'h0,     E_TRAP},
        '{"R6", 64'h1108, 64'h1000, 6'd3, 64'd40, K32,  64'h2_0000_0000, 1'b1, 64'hBAD00, E_REDIR},
        '{"R5", 64'h1108, 64'h1000, 6'd3, 64'd40, K64,  64'h2_0000_0000, 1'b1, 64'hBAD00, E_PASS},
        '{"R7", 64'h1000, 64'h1000, 6'd3, 64'd0,  KEQ,  64'h0,         1'b0, 64'h0,     E_PASS},
        '{"R7", 64'h1008, 64'h1000, 6'd3, 64'd8,  KEQ,  ONES,          1'b0, 64'h0,     E_TRAP},
        '{"R8", 64'h1018, 64'h1000, 6'd3, 64'd4,  KONE, 64'h0,         1'b0, 64'h0,     E_PASS},
        '{"R8", 64'h1018, 64'h1000, 6'd3, 64'd3,  KONE, 64'h0,         1'b1, 64'h7700,  E_REDIR},
        '{"R4", 64'h1000, 64'h1000, 6'd3, 64'd0,  KONE, ONES,          1'b0, 64'h0,     E_TRAP},
        '{"R3", 64'h1005, 64'h1000, 6'd0, 64'd6,  K64,  64'h20,        1'b0, 64'h0,     E_PASS},
        '{"R6", 64'h1010, 64'h1000, 6'd3, 64'd8,  K32,  64'h4,         1'b0, 64'h0,     E_PASS}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic           req_ready;
    logic [AW-1:0]  req_target = '0;
    logic [AW-1:0]  req_base = '0;
    logic [SHW-1:0] req_shift = '0;
    logic [AW-1:0]  req_count = '0;
    logic [1:0]     req_kind = '0;
    logic [VW-1:0]  req_bits = '0;
    logic           req_redirect = 1'b0;
    logic [AW-1:0]  req_fail_target = '0;
    logic           rsp_valid;
    logic           rsp_ready = 1'b1;
    logic           rsp_pass, rsp_trap, rsp_redirect;
    logic [AW-1:0]  rsp_fail_target;

    int applied = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfi_target_checker #(.AW(AW), .VW(VW), .SHW(SHW)) i_cfi_target_checker (
        .clk, .rst_n, .req_valid, .req_ready, .req_target, .req_base, .req_shift,
        .req_count, .req_kind, .req_bits, .req_redirect, .req_fail_target,
        .rsp_valid, .rsp_ready, .rsp_pass, .rsp_trap, .rsp_redirect, .rsp_fail_target
    );

    task automatic check(input string req, input logic [AW+3:0] act, input logic [AW+3:0] exp);
        applied++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        req_target      = v.tgt;
        req_base        = v.base;
        req_shift       = v.sh;
        req_count       = v.cnt;
        req_kind        = v.kind;
        req_bits        = v.bits;
        req_redirect    = v.redir;
        req_fail_target = v.ftgt;
        req_valid       = 1'b1;
    endtask

    function automatic logic [AW+3:0] expect_of(input vec_t v);
        logic pass_e = (v.exp == E_PASS);
        logic trap_e = (v.exp == E_TRAP);
        logic red_e  = (v.exp == E_REDIR);
        return {1'b1, pass_e, trap_e, red_e, red_e ? v.ftgt : {AW{1'b0}}};
    endfunction

    function automatic logic [AW+3:0] observed();
        return {rsp_valid, rsp_pass, rsp_trap, rsp_redirect, rsp_fail_target};
    endfunction

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
            $finish;
        end
    endtask

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        miscompares++;
        applied++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state, R1: ready after reset
        check("R10", observed(), '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {{(AW+3){1'b0}}, req_ready}, {{(AW+3){1'b0}}, 1'b1});
        check("R10", observed(), '0);

        for (int i = 0; i < NVEC; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            req_valid = 1'b0;
            check(string'(VECS[i].tag), observed(), expect_of(VECS[i]));   // R2 and R9 per vector
            @(negedge clk);
        end

        // R1: verdict held while consumer stalls
        rsp_ready = 1'b0;
        drive(VECS[2]);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", observed(), expect_of(VECS[2]));
        check("R1", {{(AW+3){1'b0}}, req_ready}, '0);
        rsp_ready = 1'b1;
        @(negedge clk);
        check("R1", {{(AW+3){1'b0}}, rsp_valid}, '0);
        check("R1", {{(AW+3){1'b0}}, req_ready}, {{(AW+3){1'b0}}, 1'b1});

        // R8 again: all-ones kind ignores vector content for an out-of-range index
        drive('{"R8", 64'h1040, 64'h1000, 6'd3, 64'd8, KONE, ONES, 1'b0, 64'h0, E_TRAP});
        @(negedge clk);
        req_valid = 1'b0;
        check("R8", observed(), {1'b1, 1'b0, 1'b1, 1'b0, {AW{1'b0}}});
        @(negedge clk);

        summary();
    end
endmodule